// File: doc/BRIEF.md
# Serial Accumulating Adder

This block adds two unsigned WIDTH-bit numbers with a single full-adder slice, one bit pair per clock. The augend lives in register A and the addend in register B; both shift right together, the slice adds their least significant bits plus a stored carry, and the sum bit enters A from the top. After WIDTH shifts A holds the sum and the carry flip-flop holds the carry-out of the whole add. The result therefore replaces the augend in place.

While B shifts, a serial input fills it from the top, one bit per shift and least significant bit first. So when one add finishes, B already holds the next operand, and a new start adds it to the running total in A. A built-in counter runs the shifting for exactly WIDTH cycles after an accepted start and then flags completion for one cycle. To sum a list of numbers from a cleared state, clear the block, run one add while streaming in the first number, and then run one add per further number.

Top module: `ser_acc_add`

## Requirements
- R1: `clr_i` high at a clock edge sets A, B, the carry, `busy_o` and `done_o` to 0 on that edge. It wins over every other input, including an add in progress.
- R2: With the block idle and `clr_i` low, `load_i` at an edge loads A from `aug_i` and B from `add_i`, and clears the carry.
- R3: `start_i` with the block idle is accepted at that edge and raises `busy_o`. Exactly WIDTH shift edges follow. `done_o` is high for exactly one cycle, beginning at the WIDTH-th edge after the accepting edge, and `busy_o` drops at that same edge.
- R4: When `done_o` is high, `sum_o` equals (A + B) mod 2^WIDTH for the A and B present at the start, and `cout_o` equals the carry-out of that add.
- R5: On each shift, B takes `sin_i` into its most significant bit. After a full add, B holds the WIDTH bits sampled on the shift edges, with the first sampled bit in bit 0.
- R6: Repeated starts with no load in between accumulate. Each add adds the value streamed during the previous add to A. Starting from a clear, the first add streams in the first operand and leaves A at 0.
- R7: `start_i` while `busy_o` is high is ignored. The running add keeps its original timing and does not restart.
- R8: While idle, with no load, clear or start, A and the carry keep their values whatever `sin_i` does.
- R9: `load_i` and `start_i` together while idle load the operands and start an add on them.
- R10: `load_i` while `busy_o` is high is ignored, and the result is that of the running add.
- R11: An accepted start clears the carry. `cout_o` keeps the carry-out of the last add until the next start, load or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| clr_i | input | 1 | Synchronous clear of all state |
| load_i | input | 1 | Parallel load of both operand registers when idle |
| aug_i | input | WIDTH | Augend to load into A |
| add_i | input | WIDTH | Addend to load into B |
| start_i | input | 1 | Begin a WIDTH-cycle serial add when idle |
| sin_i | input | 1 | Serial fill bit for B, sampled on each shift |
| sum_o | output | WIDTH | Contents of A (running result) |
| cout_o | output | 1 | Carry flip-flop; carry-out after an add |
| busy_o | output | 1 | Shifting in progress |
| done_o | output | 1 | One-cycle pulse when an add completes |

## Verification
The case that matters most is when a control input arrives while shifting is under way. A second start or a parallel load can land on any shift cycle, and a clear can do so too. Each of these is injected mid-run on a chosen shift. The bench then judges the outcome from the completion pulse's timing and from the final sum and carry: an ignored start or load must leave both exactly as a clean run would, and a clear must zero the state at once with no completion pulse afterwards. A load and a start in the same idle cycle are also driven, and the bench checks that the add runs on the newly loaded operands.

// File: rtl/sa_pkg.sv
package sa_pkg;

   typedef enum logic [1:0] {
      SA_HOLD  = 2'd0,
      SA_LOAD  = 2'd1,
      SA_SHIFT = 2'd2,
      SA_CLEAR = 2'd3
   } sa_op_e;

   function automatic logic fa_sum(input logic a, input logic b, input logic c);
      return a ^ b ^ c;
   endfunction

   function automatic logic fa_carry(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/sa_shreg.sv
module sa_shreg
   import sa_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk_i,
   input  sa_op_e           op_i,
   input  logic [WIDTH-1:0] par_i,
   input  logic             ser_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] q;

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      logic from_left;
      if (i == WIDTH-1) begin : g_top
         assign from_left = ser_i;
      end else begin : g_mid
         assign from_left = q[i+1];
      end

      always_ff @(posedge clk_i) begin
         unique case (op_i)
            SA_CLEAR: q[i] <= 1'b0;
            SA_LOAD:  q[i] <= par_i[i];
            SA_SHIFT: q[i] <= from_left;
            default:  q[i] <= q[i];
         endcase
      end
   end

   assign q_o = q;

endmodule

// File: rtl/sa_fa_slice.sv
module sa_fa_slice
   import sa_pkg::*;
(
   input  logic   clk_i,
   input  sa_op_e op_i,
   input  logic   start_acc_i,
   input  logic   a_i,
   input  logic   b_i,
   output logic   sum_o,
   output logic   carry_o
);

   logic carry_q;

   assign sum_o = fa_sum(a_i, b_i, carry_q);

   always_ff @(posedge clk_i) begin
      if (op_i == SA_CLEAR || op_i == SA_LOAD || start_acc_i)
         carry_q <= 1'b0;
      else if (op_i == SA_SHIFT)
         carry_q <= fa_carry(a_i, b_i, carry_q);
   end

   assign carry_o = carry_q;

endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl
   import sa_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic   clk_i,
   input  logic   clr_i,
   input  logic   load_i,
   input  logic   start_i,
   output sa_op_e op_o,
   output logic   start_acc_o,
   output logic   busy_o,
   output logic   done_o
);

   localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [CW-1:0] LAST = CW'(WIDTH-1);

   logic [CW-1:0] cnt;
   logic          busy_q;
   logic          done_q;
   logic          last;

   assign last        = busy_q && (cnt == LAST);
   assign start_acc_o = !clr_i && !busy_q && start_i;

   always_ff @(posedge clk_i) begin
      if (clr_i) begin
         cnt    <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (busy_q) begin
            if (last) begin
               cnt    <= '0;
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else if (start_i) begin
            cnt    <= '0;
            busy_q <= 1'b1;
         end
      end
   end

   always_comb begin
      if (clr_i)       op_o = SA_CLEAR;
      else if (busy_q) op_o = SA_SHIFT;
      else if (load_i) op_o = SA_LOAD;
      else             op_o = SA_HOLD;
   end

   assign busy_o = busy_q;
   assign done_o = done_q;

   // R3: completion is a single-cycle pulse
   a_r3_done_single: assert property (@(posedge clk_i) disable iff (clr_i)
      done_q |=> !done_q);

   // R3: completion only follows a shifting cycle
   a_r3_done_after_busy: assert property (@(posedge clk_i) disable iff (clr_i)
      $rose(done_q) |-> !busy_q && $past(busy_q));

   // R3: counter never leaves its range
   a_r3_cnt_range: assert property (@(posedge clk_i) disable iff (clr_i)
      busy_q |-> cnt <= LAST);

   // R7: a running add is not cut short or restarted
   a_r7_no_restart: assert property (@(posedge clk_i) disable iff (clr_i)
      (busy_q && !last) |=> busy_q && cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/ser_acc_add.sv
module ser_acc_add
   import sa_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             clr_i,
   input  logic             load_i,
   input  logic [WIDTH-1:0] aug_i,
   input  logic [WIDTH-1:0] add_i,
   input  logic             start_i,
   input  logic             sin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             busy_o,
   output logic             done_o
);

   initial begin
      assert (WIDTH >= 2) else $error("ser_acc_add: WIDTH must be at least 2");
   end

   sa_op_e           op;
   logic             start_acc;
   logic [WIDTH-1:0] a_q;
   logic [WIDTH-1:0] b_q;
   logic             sum_bit;
   logic             carry_q;

   sa_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk_i       (clk_i),
      .clr_i       (clr_i),
      .load_i      (load_i),
      .start_i     (start_i),
      .op_o        (op),
      .start_acc_o (start_acc),
      .busy_o      (busy_o),
      .done_o      (done_o)
   );

   sa_shreg #(.WIDTH(WIDTH)) u_areg (
      .clk_i (clk_i),
      .op_i  (op),
      .par_i (aug_i),
      .ser_i (sum_bit),
      .q_o   (a_q)
   );

   sa_shreg #(.WIDTH(WIDTH)) u_breg (
      .clk_i (clk_i),
      .op_i  (op),
      .par_i (add_i),
      .ser_i (sin_i),
      .q_o   (b_q)
   );

   sa_fa_slice u_slice (
      .clk_i       (clk_i),
      .op_i        (op),
      .start_acc_i (start_acc),
      .a_i         (a_q[0]),
      .b_i         (b_q[0]),
      .sum_o       (sum_bit),
      .carry_o     (carry_q)
   );

   assign sum_o  = a_q;
   assign cout_o = carry_q;

   // R1: clear empties every register
   a_r1_clear: assert property (@(posedge clk_i)
      clr_i |=> sum_o == '0 && !cout_o && !busy_o && !done_o);

   // R2: idle load takes the augend and zeroes the carry
   a_r2_load: assert property (@(posedge clk_i) disable iff (clr_i)
      (load_i && !busy_o) |=> sum_o == $past(aug_i) && !cout_o);

   // R8: idle with no command keeps A and the carry
   a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (clr_i)
      (!busy_o && !load_i && !start_i) |=> $stable(sum_o) && $stable(cout_o));

   // R11: accepted start zeroes the carry
   a_r11_start_clears: assert property (@(posedge clk_i) disable iff (clr_i)
      (start_i && !busy_o) |=> busy_o && !cout_o);

endmodule

// File: tb/ser_acc_add_test.sv
module ser_acc_add_test;

   localparam int W = 8;
   localparam int NV = 6;

   // entry: {augend, addend, next operand streamed during the add}
   localparam logic [3*W-1:0] VEC [NV] = '{
      {8'h00, 8'h00, 8'h01},
      {8'h12, 8'h34, 8'h56},
      {8'hFF, 8'h01, 8'h0F},
      {8'hFF, 8'hFF, 8'hFF},
      {8'hA5, 8'h5A, 8'h80},
      {8'h7F, 8'h80, 8'h33}
   };

   logic         clk = 1'b0;
   logic         clr = 1'b1;
   logic         load = 1'b0;
   logic [W-1:0] aug = '0;
   logic [W-1:0] addv = '0;
   logic         start = 1'b0;
   logic         sin = 1'b0;
   logic [W-1:0] sum;
   logic         cout;
   logic         busy;
   logic         done;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   ser_acc_add #(.WIDTH(W)) uut (
      .clk_i   (clk),
      .clr_i   (clr),
      .load_i  (load),
      .aug_i   (aug),
      .add_i   (addv),
      .start_i (start),
      .sin_i   (sin),
      .sum_o   (sum),
      .cout_o  (cout),
      .busy_o  (busy),
      .done_o  (done)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
      @(negedge clk);
      load = 1'b1; aug = a; addv = b;
      @(posedge clk);
      @(negedge clk);
      load = 1'b0;
   endtask

   // inj: 0 none, 1 second start mid-run, 2 load mid-run
   task automatic run_add(input logic [W-1:0] nb, input int inj);
      @(negedge clk);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < W; i++) begin
         sin = nb[i];
         if (i == 3 && inj == 1) start = 1'b1;
         if (i == 3 && inj == 2) begin load = 1'b1; aug = 8'hFF; addv = 8'hFF; end
         chk("R3 busy during shift", busy, 1);
         chk("R3 no early done", done, 0);
         @(posedge clk);
         @(negedge clk);
         start = 1'b0;
         load = 1'b0;
      end
      chk("R3 done pulse", done, 1);
      chk("R3 busy dropped", busy, 0);
   endtask

   initial begin
      logic [W-1:0] a, b, nx;
      logic [W:0]   full;
      logic [W-1:0] keep;

      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R1 reset sum", sum, 0);
      chk("R1 reset cout", cout, 0);
      chk("R1 reset busy", busy, 0);
      chk("R1 reset done", done, 0);
      clr = 1'b0;

      // table walk: R2 R4 R5 R6
      for (int v = 0; v < NV; v++) begin
         {a, b, nx} = VEC[v];
         do_load(a, b);
         chk("R2 load sum", sum, a);
         chk("R2 load cout", cout, 0);
         run_add(nx, 0);
         full = a + b;
         chk("R4 sum", sum, full[W-1:0]);
         chk("R4 cout", cout, full[W]);
         keep = full[W-1:0];
         run_add(8'h00, 0);
         full = keep + nx;
         chk("R5 R6 streamed operand sum", sum, full[W-1:0]);
         chk("R6 accumulate cout", cout, full[W]);
         @(negedge clk);
         chk("R3 done one cycle", done, 0);
      end

      // R8 R11: idle hold with sin toggling, carry kept
      do_load(8'hF0, 8'h20);
      run_add(8'h00, 0);
      chk("R11 cout set", cout, 1);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         sin = k[0];
      end
      chk("R8 idle sum", sum, 8'h10);
      chk("R11 cout held", cout, 1);

      // R7: second start mid-run ignored
      do_load(8'h03, 8'h04);
      run_add(8'h00, 1);
      chk("R7 sum", sum, 8'h07);
      @(negedge clk);
      chk("R7 no restart busy", busy, 0);
      chk("R7 done once", done, 0);

      // R10: load mid-run ignored
      do_load(8'h03, 8'h04);
      run_add(8'h00, 2);
      chk("R10 sum", sum, 8'h07);
      chk("R10 cout", cout, 0);

      // R9: load and start in the same idle cycle
      @(negedge clk);
      load = 1'b1; aug = 8'hC8; addv = 8'h64; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      load = 1'b0; start = 1'b0;
      for (int i = 0; i < W; i++) begin
         sin = 1'b0;
         @(posedge clk);
      end
      @(negedge clk);
      chk("R9 done", done, 1);
      chk("R9 sum", sum, 8'h2C);
      chk("R9 cout", cout, 1);

      // R1: clear mid-run aborts
      do_load(8'h55, 8'h55);
      @(negedge clk);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      clr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      clr = 1'b0;
      chk("R1 abort sum", sum, 0);
      chk("R1 abort busy", busy, 0);
      chk("R1 abort cout", cout, 0);
      keep = 8'h00;
      for (int k = 0; k < W + 2; k++) begin
         @(negedge clk);
         if (done) keep = 8'h01;
      end
      chk("R1 no done after abort", keep, 0);

      // R6: clear, stream first number, then accumulate two more
      run_add(8'h2A, 0);
      chk("R6 first pass sum", sum, 8'h00);
      run_add(8'h11, 0);
      chk("R6 second pass sum", sum, 8'h2A);
      run_add(8'h00, 0);
      chk("R6 third pass sum", sum, 8'h3B);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule